// File: doc/BRIEF.md
# Byte-Wide Strobed Register Port

This block connects an 8-bit host bus with separate active-low read and write strobes to a bank of up to 128 byte registers. It does not use an address bus. A single internal address pointer selects the register. A one-bit state decides what a write does: in address state the written byte becomes the pointer, and in data state it goes to the register the pointer selects. Both strobes arrive without a clock relation to the block, so each passes through a two-flop synchronizer before any action is taken.

The low addresses hold a multi-byte output value: an interpolation byte, then the bytes of a position count with the least significant byte first, then a speed byte. A snapshot copies these live values at the start of a read, so a host can read every byte of one sample in consecutive accesses. A configured output length (one to four bytes) controls two things: when the snapshot is refreshed, and how the pointer moves after each read. The incremental-track byte and the status byte are the exceptions: they follow their live inputs even while a read is in progress. Register writes leave the block as a one-cycle enable together with the address and the data.

Top module: `ubus_regport`

## Requirements
- R1: After reset the pointer is 0, the state is address, `bus_oe` is low, `bus_out` is 0 and `wr_en` is low.
- R2: A completed write in address state loads the pointer with the low 7 bits of the bus byte, produces no `wr_en`, and moves the state to data.
- R3: A completed write in data state produces exactly one `wr_en` pulse. The pulse carries the pointer value as `wr_addr` and the bus byte that was present while the write strobe was low as `wr_data`.
- R4: Each data-state write advances the pointer by one, wrapping from 127 to 0. The state stays data.
- R5: Every completed read returns the state to address.
- R6: When `len_sel` is 0 (one-byte output), a read leaves the pointer unchanged.
- R7: When `len_sel` is 1 to 3, a read at an address equal to `len_sel` sets the pointer to 0. Any other read advances it by one.
- R8: At the start of a read, the snapshot of position (address 0), count (addresses 1 to 3, least significant byte first) and speed (address 5) is refreshed when `len_sel` is 0 or the pointer is 0. Other reads return the held snapshot.
- R9: The read byte stays fixed for the whole read, except at address 4 (`live_inc`) and address 6 (`live_stat`), which follow their inputs while the read is in progress.
- R10: Addresses 7 to 15 return `reg_rdata` as sampled at the start of the read. Addresses 16 to 127 return 0.
- R11: Whenever both synchronized strobes are low together, the accesses in progress are discarded: no write, no pointer change, no state change.
- R12: `bus_oe` is high only during an accepted read. Outside a read, `bus_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_in | input | 8 | Byte from the host bus |
| bus_out | output | 8 | Byte returned to the host bus |
| bus_oe | output | 1 | Bus drive enable during a read |
| len_sel | input | 2 | Output length minus one (0 = one byte) |
| live_pos | input | 8 | Live interpolation byte |
| live_count | input | 24 | Live position count |
| live_speed | input | 8 | Live speed byte |
| live_inc | input | 8 | Live incremental-track byte (not frozen) |
| live_stat | input | 8 | Live status byte (not frozen) |
| reg_addr | output | 7 | Current pointer value |
| reg_rdata | input | 8 | Byte of the register at `reg_addr` (addresses 7 to 15) |
| wr_en | output | 1 | One-cycle register write enable |
| wr_addr | output | 7 | Address of the register write |
| wr_data | output | 8 | Data of the register write |

## Verification
The bench builds the block with its default parameters: a 7-bit pointer, a 24-bit count and the write-only region starting at 16. With these values, a single data write at address 127 shows the pointer wrapping, and a read at address 32 falls inside the region that returns zero. The count sits at addresses 1 to 3 with the speed byte at 5. This places the output-length boundary at every possible `len_sel`, so the bench checks both the reset-to-zero case and the plain-advance case of the post-read pointer rule.

// File: rtl/ubus_regport.sv
module ubus_regport #(
  parameter int AW       = 7,
  parameter int CW       = 24,
  parameter int CAL_BASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [7:0]    bus_in,
  output logic [7:0]    bus_out,
  output logic          bus_oe,
  input  logic [1:0]    len_sel,
  input  logic [7:0]    live_pos,
  input  logic [CW-1:0] live_count,
  input  logic [7:0]    live_speed,
  input  logic [7:0]    live_inc,
  input  logic [7:0]    live_stat,
  output logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_rdata,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CB = CW / 8;
  localparam logic [AW-1:0] A_INC  = AW'(CB + 1);
  localparam logic [AW-1:0] A_SPD  = AW'(CB + 2);
  localparam logic [AW-1:0] A_STAT = AW'(CB + 3);
  localparam logic [AW-1:0] A_CFG  = AW'(CB + 4);
  localparam logic [AW-1:0] A_CAL  = AW'(CAL_BASE);

  logic [1:0]    rd_sy, wr_sy;
  logic          rd_d, wr_d, rd_act, wr_act, st_data;
  logic [AW-1:0] addr;
  logic [7:0]    wr_cap, hold, snap_pos, snap_spd;
  logic [CW-1:0] snap_cnt;

  wire rd_s    = rd_sy[1];
  wire wr_s    = wr_sy[1];
  wire rd_fall = rd_d & ~rd_s;
  wire rd_rise = ~rd_d & rd_s;
  wire wr_fall = wr_d & ~wr_s;
  wire wr_rise = ~wr_d & wr_s;
  wire clash   = ~rd_s & ~wr_s;

  wire           snap_now = (len_sel == 2'd0) || (addr == '0);
  wire [7:0]     pos_n    = snap_now ? live_pos   : snap_pos;
  wire [CW-1:0]  cnt_n    = snap_now ? live_count : snap_cnt;
  wire [7:0]     spd_n    = snap_now ? live_speed : snap_spd;
  wire           top_byte = (addr == {{(AW-2){1'b0}}, len_sel});

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == '0) rd_mux = pos_n;
    for (int i = 0; i < CB; i++)
      if (addr == AW'(i + 1)) rd_mux = cnt_n[8*i +: 8];
    if (addr == A_SPD) rd_mux = spd_n;
    if (addr >= A_CFG && addr < A_CAL) rd_mux = reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sy    <= 2'b11;
      wr_sy    <= 2'b11;
      rd_d     <= 1'b1;
      wr_d     <= 1'b1;
      rd_act   <= 1'b0;
      wr_act   <= 1'b0;
      st_data  <= 1'b0;
      addr     <= '0;
      wr_cap   <= '0;
      hold     <= '0;
      snap_pos <= '0;
      snap_cnt <= '0;
      snap_spd <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      rd_sy <= {rd_sy[0], rd_n};
      wr_sy <= {wr_sy[0], wr_n};
      rd_d  <= rd_s;
      wr_d  <= wr_s;
      wr_en <= 1'b0;
      if (!wr_sy[0]) wr_cap <= bus_in;
      if (clash) begin
        rd_act <= 1'b0;
        wr_act <= 1'b0;
      end else begin
        if (rd_fall && wr_s) begin
          rd_act <= 1'b1;
          hold   <= rd_mux;
          if (snap_now) begin
            snap_pos <= live_pos;
            snap_cnt <= live_count;
            snap_spd <= live_speed;
          end
        end
        if (rd_rise && rd_act) begin
          rd_act  <= 1'b0;
          st_data <= 1'b0;
          if (len_sel != 2'd0) addr <= top_byte ? '0 : addr + 1'b1;
        end
        if (wr_fall && rd_s) wr_act <= 1'b1;
        if (wr_rise && wr_act) begin
          wr_act  <= 1'b0;
          st_data <= 1'b1;
          if (st_data) begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= wr_cap;
            addr    <= addr + 1'b1;
          end else begin
            addr <= wr_cap[AW-1:0];
          end
        end
      end
    end
  end

  assign reg_addr = addr;
  assign bus_oe   = rd_act;
  assign bus_out  = !rd_act          ? 8'h00 :
                    (addr == A_INC)  ? live_inc :
                    (addr == A_STAT) ? live_stat : hold;
endmodule

// File: rtl/ubus_regport_chk.sv
module ubus_regport_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_oe,
  input logic [7:0]    bus_out,
  input logic [AW-1:0] reg_addr,
  input logic [1:0]    len_sel,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          st_data
);
  a_r3_write_needs_data_state: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(st_data));

  a_r4_pointer_steps_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (reg_addr == AW'(wr_addr + 1'b1)));

  a_r5_read_ends_in_address_state: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> !st_data);

  a_r6_single_byte_pointer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_oe) && len_sel == 2'd0 && $stable(len_sel)) |-> $stable(reg_addr));

  a_r7_top_byte_returns_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_oe) && len_sel != 2'd0 && $stable(len_sel) &&
     $past(reg_addr) == {{(AW-2){1'b0}}, len_sel}) |-> (reg_addr == '0));

  a_r9_read_byte_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && reg_addr != AW'(4) && reg_addr != AW'(6)) |-> $stable(bus_out));

  a_r11_no_write_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !wr_en);
endmodule

bind ubus_regport ubus_regport_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .reg_addr(reg_addr), .len_sel(len_sel), .wr_en(wr_en),
  .wr_addr(wr_addr), .st_data(st_data)
);

// File: tb/ubus_regport_tb_top.sv
`timescale 1ns/1ps
module ubus_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [1:0]  len_sel = 2'd3;
  logic [7:0]  live_pos = 8'hA5, live_speed = 8'h3C, live_inc = 8'h11, live_stat = 8'h00;
  logic [23:0] live_count = 24'h123456;
  logic [6:0]  reg_addr, wr_addr;
  logic [7:0]  reg_rdata, wr_data;
  logic        wr_en;
  int n_chk = 0, n_bad = 0, wcnt = 0, exp_w = 0;
  logic [6:0] last_a = '0;
  logic [7:0] last_d = '0;

  always #2.5 clk = ~clk;
  assign reg_rdata = 8'h80 ^ {1'b0, reg_addr};

  ubus_regport dut_i (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .len_sel(len_sel), .live_pos(live_pos),
    .live_count(live_count), .live_speed(live_speed), .live_inc(live_inc),
    .live_stat(live_stat), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) if (wr_en) begin
    wcnt++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  // {read, data_or_address, expected}
  localparam logic [16:0] VEC [0:10] = '{
    {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'hA5}, {1'b1, 8'h00, 8'h56},
    {1'b1, 8'h00, 8'h34}, {1'b1, 8'h00, 8'h12}, {1'b0, 8'h05, 8'h00},
    {1'b1, 8'h00, 8'h3C}, {1'b0, 8'h09, 8'h00}, {1'b1, 8'h00, 8'h89},
    {1'b0, 8'h20, 8'h00}, {1'b1, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); bus_in = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_begin();
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_end();
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    read_begin();
    chk(req, bus_out, exp);
    read_end();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pointer", reg_addr, 0);
    chk("R1 oe", bus_oe, 0);
    chk("R12 bus idle", bus_out, 0);
    chk("R1 wr_en", wr_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      if (VEC[i][16]) read_chk("R8 R10 table read", VEC[i][7:0]);
      else bus_write(VEC[i][15:8]);
    end

    bus_write(8'h0A);
    chk("R2 pointer load", reg_addr, 8'h0A);
    chk("R2 no write", wcnt, exp_w);
    bus_write(8'hAA); exp_w++;
    chk("R3 count", wcnt, exp_w);
    chk("R3 addr", last_a, 8'h0A);
    chk("R3 data", last_d, 8'hAA);
    chk("R4 step", reg_addr, 8'h0B);
    bus_write(8'hBB); exp_w++;
    chk("R3 second data", last_d, 8'hBB);
    chk("R4 second step", reg_addr, 8'h0C);

    read_begin();
    chk("R12 oe during read", bus_oe, 1);
    read_end();
    chk("R12 oe after read", bus_oe, 0);
    chk("R12 bus after read", bus_out, 0);
    bus_write(8'h7F);
    bus_write(8'h11); exp_w++;
    chk("R4 wrap addr", last_a, 8'h7F);
    chk("R4 wrap pointer", reg_addr, 0);

    read_begin(); read_end();
    bus_write(8'h05);
    chk("R5 address state after read", reg_addr, 8'h05);
    chk("R5 no write", wcnt, exp_w);

    read_begin(); read_end();
    len_sel = 2'd0;
    bus_write(8'h02);
    read_chk("R8 single byte snapshot", 8'h34);
    chk("R6 pointer kept", reg_addr, 8'h02);
    live_count = 24'hABCDEF;
    read_chk("R8 resnapshot len0", 8'hCD);
    chk("R6 pointer kept again", reg_addr, 8'h02);

    len_sel = 2'd3;
    bus_write(8'h00);
    read_chk("R8 position byte", 8'hA5);
    live_count = 24'h000000;
    read_chk("R8 coherent count", 8'hEF);

    bus_write(8'h05);
    read_begin();
    chk("R9 speed", bus_out, 8'h3C);
    live_speed = 8'h77;
    repeat (3) @(negedge clk);
    chk("R9 frozen", bus_out, 8'h3C);
    read_end();
    bus_write(8'h04);
    read_begin();
    chk("R9 live inc", bus_out, 8'h11);
    live_inc = 8'h22;
    repeat (2) @(negedge clk);
    chk("R9 inc follows", bus_out, 8'h22);
    read_end();
    bus_write(8'h06);
    live_stat = 8'h03;
    read_begin();
    live_stat = 8'h09;
    @(negedge clk);
    chk("R9 status follows", bus_out, 8'h09);
    read_end();

    len_sel = 2'd1;
    bus_write(8'h00);
    read_begin(); read_end();
    chk("R7 advance", reg_addr, 1);
    read_begin(); read_end();
    chk("R7 top byte to zero", reg_addr, 0);
    bus_write(8'h09);
    read_begin(); read_end();
    chk("R7 other advance", reg_addr, 8'h0A);

    bus_write(8'h07);
    @(negedge clk); bus_in = 8'h55; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 no drive on clash", bus_oe, 0);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 no write", wcnt, exp_w);
    chk("R11 pointer kept", reg_addr, 8'h07);
    bus_write(8'h66); exp_w++;
    chk("R11 state kept addr", last_a, 8'h07);
    chk("R11 state kept data", last_d, 8'h66);

    read_chk("R10 config byte", 8'h88);
    bus_write(8'h10);
    read_chk("R10 write-only region", 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule